// File: doc/BRIEF.md
# Byte-wide logic and arithmetic unit

This block is a purely combinational unit that combines two byte operands under a 3-bit operation select and returns a byte result in the same cycle. It has no internal state, so the result follows the current inputs only. The unit is meant to sit between a register file and a result bus in a small datapath. A surrounding controller presents both operands and a code, and then captures the result on its own clock edge.

All four bitwise functions come from one AND array. A control pair can invert both operands before the AND and can invert the AND output after it. The four combinations of these two controls give AND, NAND, NOR and OR, as De Morgan's laws predict. Addition runs through a ripple chain of full adders. Subtraction reuses that chain: it feeds in the inverted second operand and forces the carry-in high. The carry leaving the top bit is not built, so every arithmetic result wraps modulo 256. The two unassigned codes return zero.

Top module: `byte_alu`

## Requirements
- R1: Operation select 3'b000 and 3'b111 both drive the result to all zeros, whatever the operands are.
- R2: Operation select 3'b001 gives the bitwise OR of operand A and operand B.
- R3: Operation select 3'b010 gives the bitwise NAND of A and B.
- R4: Operation select 3'b011 gives the bitwise NOR of A and B.
- R5: Operation select 3'b100 gives the bitwise AND of A and B.
- R6: Operation select 3'b101 gives (A + B) mod 256. The carry out of bit 7 is dropped, so 8'hFF + 8'h01 gives 8'h00.
- R7: Operation select 3'b110 gives (A - B) mod 256, formed as A + ~B + 1. For example, 8'h00 - 8'h01 gives 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 8 | First operand |
| opd_b | input | 8 | Second operand; the subtrahend for 3'b110 |
| op_sel | input | 3 | Operation select code |
| result | output | 8 | Combinational result |

## Verification
The bench builds the unit with its default width of 8. At that width the whole code space can be covered, and the wrap points can be reached directly: 8'hFF plus 8'h01 tests the dropped carry, 8'h00 minus 8'h01 tests the borrow wrap, and the transitions across 8'h7F/8'h80 are also driven. Every one of the eight codes is exercised against an independent reference, using fixed corner operands together with a few hundred random operand pairs per code. Both reserved codes are driven with all-ones operands, to show that no operand bit leaks into the result.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_RSVD_LO = 3'b000,
        OP_OR      = 3'b001,
        OP_NAND    = 3'b010,
        OP_NOR     = 3'b011,
        OP_AND     = 3'b100,
        OP_ADD     = 3'b101,
        OP_SUB     = 3'b110,
        OP_RSVD_HI = 3'b111
    } op_e;

    typedef struct packed {
        logic inv_in;    // invert both operands ahead of the AND array
        logic inv_out;   // invert the AND array output
        logic use_arith; // take the adder path instead of the logic path
        logic negate_b;  // subtract: feed ~B and force carry-in
        logic force_zero;
    } ctrl_t;

endpackage

// File: rtl/byte_alu_logic.sv
module byte_alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             inv_in,
    input  logic             inv_out,
    output logic [WIDTH-1:0] y
);
    logic [WIDTH-1:0] pre_a;
    logic [WIDTH-1:0] pre_b;
    logic [WIDTH-1:0] and_q;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign pre_a[i] = in_a[i] ^ inv_in;
            assign pre_b[i] = in_b[i] ^ inv_in;
            assign and_q[i] = pre_a[i] & pre_b[i];
            assign y[i]     = and_q[i] ^ inv_out;
        end
    endgenerate
endmodule

// File: rtl/byte_alu_fa.sv
module byte_alu_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;
    assign half = x ^ y;
    assign s    = half ^ ci;
    assign co   = (x & y) | (half & ci);
endmodule

// File: rtl/byte_alu_adder.sv
module byte_alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] carry;
    assign carry[0] = cin;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            if (i < TOP) begin : g_full
                byte_alu_fa fa_i (
                    .x  (in_a[i]),
                    .y  (in_b[i]),
                    .ci (carry[i]),
                    .s  (sum[i]),
                    .co (carry[i+1])
                );
            end else begin : g_last
                // most significant stage: its carry out is never formed
                assign sum[i] = in_a[i] ^ in_b[i] ^ carry[i];
            end
        end
    endgenerate
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    input  logic [OP_W-1:0]  op_sel,
    output logic [WIDTH-1:0] result
);
    ctrl_t            ctrl;
    op_e              op;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] arith_b;
    logic [WIDTH-1:0] arith_y;

    assign op = op_e'(op_sel);

    always_comb begin
        ctrl = '0;
        unique case (op)
            OP_AND:  ctrl = '{inv_in: 1'b0, inv_out: 1'b0, use_arith: 1'b0, negate_b: 1'b0, force_zero: 1'b0};
            OP_NAND: ctrl = '{inv_in: 1'b0, inv_out: 1'b1, use_arith: 1'b0, negate_b: 1'b0, force_zero: 1'b0};
            OP_NOR:  ctrl = '{inv_in: 1'b1, inv_out: 1'b0, use_arith: 1'b0, negate_b: 1'b0, force_zero: 1'b0};
            OP_OR:   ctrl = '{inv_in: 1'b1, inv_out: 1'b1, use_arith: 1'b0, negate_b: 1'b0, force_zero: 1'b0};
            OP_ADD:  ctrl = '{inv_in: 1'b0, inv_out: 1'b0, use_arith: 1'b1, negate_b: 1'b0, force_zero: 1'b0};
            OP_SUB:  ctrl = '{inv_in: 1'b0, inv_out: 1'b0, use_arith: 1'b1, negate_b: 1'b1, force_zero: 1'b0};
            OP_RSVD_LO,
            OP_RSVD_HI: ctrl = '{inv_in: 1'b0, inv_out: 1'b0, use_arith: 1'b0, negate_b: 1'b0, force_zero: 1'b1};
            default: ctrl = '{inv_in: 1'b0, inv_out: 1'b0, use_arith: 1'b0, negate_b: 1'b0, force_zero: 1'b1};
        endcase
    end

    byte_alu_logic #(.WIDTH(WIDTH)) logic_i (
        .in_a    (opd_a),
        .in_b    (opd_b),
        .inv_in  (ctrl.inv_in),
        .inv_out (ctrl.inv_out),
        .y       (logic_y)
    );

    assign arith_b = opd_b ^ {WIDTH{ctrl.negate_b}};

    byte_alu_adder #(.WIDTH(WIDTH)) adder_i (
        .in_a (opd_a),
        .in_b (arith_b),
        .cin  (ctrl.negate_b),
        .sum  (arith_y)
    );

    always_comb begin
        if (ctrl.force_zero)
            result = '0;
        else if (ctrl.use_arith)
            result = arith_y;
        else
            result = logic_y;
    end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opd_a,
    input logic [WIDTH-1:0] opd_b,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] ref_sum;
    logic [WIDTH-1:0] ref_diff;

    assign ref_sum  = opd_a + opd_b;
    assign ref_diff = opd_a - opd_b;

    always_comb begin
        if (op_sel == 3'b000 || op_sel == 3'b111)
            p_zero_codes_r1: assert (result == '0);
        if (op_sel == 3'b001)
            p_or_r2: assert (result == (opd_a | opd_b));
        if (op_sel == 3'b010)
            p_nand_r3: assert (result == ~(opd_a & opd_b));
        if (op_sel == 3'b011)
            p_nor_r4: assert (result == ~(opd_a | opd_b));
        if (op_sel == 3'b100)
            p_and_r5: assert (result == (opd_a & opd_b));
        if (op_sel == 3'b101)
            p_add_wrap_r6: assert (result == ref_sum);
        if (op_sel == 3'b110)
            p_sub_wrap_r7: assert (result == ref_diff);
    end
endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .opd_a  (opd_a),
    .opd_b  (opd_b),
    .op_sel (op_sel),
    .result (result)
);

// File: tb/byte_alu_tb_top.sv
module byte_alu_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = 3'b000;
    logic [W-1:0] res;

    always #2 clk = ~clk;  // 250 MHz

    byte_alu #(.WIDTH(W)) dut_i (
        .opd_a  (a),
        .opd_b  (b),
        .op_sel (op),
        .result (res)
    );

    typedef struct packed {
        logic [2:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp;
    } item_t;

    item_t sb_q[$];
    int    n_run  = 0;
    int    n_fail = 0;

    // independent reference model, written from the requirements
    function automatic logic [W-1:0] model(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] wide;
        case (c)
            3'b001:  return x | y;            // R2
            3'b010:  return ~(x & y);         // R3
            3'b011:  return ~(x | y);         // R4
            3'b100:  return x & y;            // R5
            3'b101:  begin wide = {1'b0, x} + {1'b0, y}; return wide[W-1:0]; end  // R6
            3'b110:  begin wide = {1'b0, x} + {1'b1, ~y} + 1; return wide[W-1:0]; end // R7
            default: return '0;               // R1
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            3'b110:  return "R7";
            default: return "R1";
        endcase
    endfunction

    // driver: apply stimulus just after a rising edge, queue the expected item
    task automatic drive(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        item_t it;
        @(posedge clk);
        #1;
        op = c;
        a  = x;
        b  = y;
        it.op  = c;
        it.a   = x;
        it.b   = y;
        it.exp = model(c, x, y);
        sb_q.push_back(it);
    endtask

    // monitor: compare at the falling edge, away from the edge that moves inputs
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (res !== it.exp) begin
                n_fail++;
                $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                         req_of(it.op), it.op, it.a, it.b, res, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(3'b000, 8'h00, 8'h00);      // reset state, R1
        // R1: reserved codes with all-ones operands must still give zero
        drive(3'b000, 8'hFF, 8'hFF);
        drive(3'b111, 8'hFF, 8'hFF);
        drive(3'b111, 8'hA5, 8'h5A);
        // R6: carry out of bit 7 dropped
        drive(3'b101, 8'hFF, 8'h01);
        drive(3'b101, 8'h80, 8'h80);
        drive(3'b101, 8'h7F, 8'h01);
        // R7: borrow wraps
        drive(3'b110, 8'h00, 8'h01);
        drive(3'b110, 8'h80, 8'h01);
        drive(3'b110, 8'h55, 8'h55);
        // R2..R5 on complementary patterns
        drive(3'b001, 8'hF0, 8'h0F);
        drive(3'b010, 8'hFF, 8'hFF);
        drive(3'b011, 8'h00, 8'h00);
        drive(3'b100, 8'hAA, 8'hFF);
        // all codes, fixed corners plus random pairs
        for (int c = 0; c < 8; c++) begin
            drive(3'(c), 8'h00, 8'hFF);
            drive(3'(c), 8'hFF, 8'h00);
            for (int k = 0; k < 200; k++)
                drive(3'(c), W'($urandom), W'($urandom));
        end
        repeat (3) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard left %0d items, expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule